// File: doc/BRIEF.md
# Write-Once Configurable Watchdog Timer

This block is a watchdog counter. Software configures it through an 8-bit mode register and restarts it through a restart register, both on a small register bus. The counter advances on clock-enable strobes from one of two sources, a low-speed internal clock or the system clock. It can also be stopped. When the count reaches the selected power-of-two period, the block raises a one-cycle reset request. The system reset controller that consumes this request lies outside the block.

The mode register accepts a single legal write after reset. That write fixes the counting source and a 3-bit overflow exponent at the same time. A strap input can lock the source to the low-speed clock, whatever source the register holds. Writing the restart key clears the count. Any other value written to the restart register is treated as a software fault, and the block requests a reset at once.

Two parameters set the exponent base of each source, so a scaled-down build can be used to check overflow timing exactly.

Top module: `wdog_timer`

## Requirements
- R1: After reset the mode register reads 0x67 and the reset request is low. In that state the counter runs on the low-speed strobe with the longest period, 2^(LOW_EXP_BASE+7) strobes.
- R2: The first write to the mode register (bus_addr=0) whose bits 7..5 equal 3'b011 is stored and read back. It also clears the counter.
- R3: Once a legal write has been stored, further writes to the mode register are ignored and the stored value is kept.
- R4: A mode write whose bits 7..5 differ from 3'b011 is ignored. It does not use up the single write allowed after reset.
- R5: Mode bits 4..3 select the count source: 00 selects the low-speed strobe, 01 selects the system strobe, and 1x stops the counter. Strobes of the source that is not selected have no effect.
- R6: Mode bits 2..0 hold the exponent n. The period is 2^(LOW_EXP_BASE+n) low-speed strobes or 2^(SYS_EXP_BASE+n) system strobes. The reset request is high for exactly one cycle, the cycle after the terminal strobe, and counting then restarts from zero.
- R7: While ls_locked is high, the low-speed strobe is used whatever value bits 4..3 hold, including the stop codes.
- R8: Writing 0xAC to the restart register (bus_addr=1) clears the counter without raising the reset request.
- R9: Writing any value other than 0xAC to the restart register raises the reset request in the next cycle for one cycle and clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ls_strobe | input | 1 | Clock-enable strobe of the low-speed source |
| sys_strobe | input | 1 | Clock-enable strobe of the system source |
| ls_locked | input | 1 | Strap that forces the low-speed source |
| bus_addr | input | 1 | Register select: 0 mode, 1 restart |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: mode register at address 0, 0x00 at address 1 |
| wdt_reset_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is the exact overflow boundary for every pairing of source and exponent. Each needs a fresh reset, because the mode register accepts only one write. The bench therefore builds with small exponent bases. For each table row it resets, writes the mode once and then alternates strobes of the wrong source and the right one, counting right-source strobes until the request appears. A request after a wrong-source strobe, or a count that differs from the period, is caught directly. The restart key, the write that clears the counter, and the locked stop code are each placed a few strobes before a known terminal count, so that a missing clear shows up as an early or late request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic [REG_W-1:0] MODE_RESET  = 8'h67;
  localparam logic [2:0]       MODE_TAG    = 3'b011;
  localparam logic [REG_W-1:0] RESTART_KEY = 8'hAC;

  typedef enum logic [1:0] {
    SRC_LOW  = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_STOP = 2'b10
  } wdt_src_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mode_q,
  output logic             accept
);
  logic             locked_q, locked_d;
  logic [REG_W-1:0] mode_d;

  always_comb begin
    accept   = wr_mode && !locked_q && (wdata[7:5] == MODE_TAG);
    mode_d   = mode_q;
    locked_d = locked_q;
    if (accept) begin
      mode_d   = wdata;
      locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RESET;
      locked_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      locked_q <= locked_d;
    end
  end

  // R3: after the single accepted write, the stored value never changes
  assert_write_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && locked_q) |=> $stable(mode_q));
  // R4: illegal tag bits leave the register untouched
  assert_illegal_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && (wdata[7:5] != MODE_TAG)) |=> $stable(mode_q));
  // R2: the stored value always carries the legal tag
  assert_tag_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7:5] == MODE_TAG);
endmodule

// File: rtl/wdt_src_sel.sv
module wdt_src_sel
  import wdt_pkg::*;
#(
  parameter int unsigned LOW_EXP_BASE = 11,
  parameter int unsigned SYS_EXP_BASE = 13,
  parameter int unsigned SH_W         = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel_bits,
  input  logic [2:0]      exp_bits,
  input  logic            ls_locked,
  input  logic            ls_strobe,
  input  logic            sys_strobe,
  output logic            tick,
  output logic [SH_W-1:0] shamt
);
  wdt_src_e src;

  always_comb begin
    if (ls_locked)              src = SRC_LOW;
    else if (sel_bits[1])       src = SRC_STOP;
    else if (sel_bits[0])       src = SRC_SYS;
    else                        src = SRC_LOW;
  end

  always_comb begin
    tick  = 1'b0;
    shamt = SH_W'(LOW_EXP_BASE) + SH_W'(exp_bits);
    unique case (src)
      SRC_LOW: tick = ls_strobe;
      SRC_SYS: begin
        tick  = sys_strobe;
        shamt = SH_W'(SYS_EXP_BASE) + SH_W'(exp_bits);
      end
      default: tick = 1'b0;
    endcase
  end

  // R5: a stop code without the strap blocks every strobe
  assert_stop_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_locked && sel_bits[1]) |-> !tick);
  // R7: the strap routes only the low-speed strobe
  assert_locked_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_locked && !ls_strobe) |-> !tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 21,
  parameter int unsigned SH_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [SH_W-1:0] shamt,
  input  logic            clear,
  input  logic            fault,
  output logic            req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term;
  logic             at_term;
  logic             req_d;

  always_comb begin
    term    = (CNT_W'(1) << shamt) - CNT_W'(1);
    at_term = (cnt_q >= term);
    cnt_d   = cnt_q;
    req_d   = 1'b0;
    if (fault) begin
      cnt_d = '0;
      req_d = 1'b1;
    end else if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      if (at_term) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req   <= req_d;
    end
  end

  // R6/R9: a request only follows a terminal strobe or a bad restart value
  assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(fault || (tick && at_term && !clear)));
  // R8: a good restart clears the count without a request
  assert_key_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !fault) |=> (cnt_q == '0) && !req);
  // R5: without a strobe or restart the count holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear && !fault) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int unsigned LOW_EXP_BASE = 11,
  parameter int unsigned SYS_EXP_BASE = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ls_strobe,
  input  logic       sys_strobe,
  input  logic       ls_locked,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_reset_req
);
  localparam int unsigned MAX_BASE = (LOW_EXP_BASE > SYS_EXP_BASE) ? LOW_EXP_BASE : SYS_EXP_BASE;
  localparam int unsigned CNT_W    = MAX_BASE + 8;
  localparam int unsigned SH_W     = $clog2(CNT_W + 1);

  logic             rst_i_n;
  logic [REG_W-1:0] mode_q;
  logic             mode_accept;
  logic             wr_mode, wr_restart;
  logic             key_ok, key_bad;
  logic             tick;
  logic [SH_W-1:0]  shamt;

  always_comb begin
    wr_mode    = bus_wr && (bus_addr == 1'b0);
    wr_restart = bus_wr && (bus_addr == 1'b1);
    key_ok     = wr_restart && (bus_wdata == RESTART_KEY);
    key_bad    = wr_restart && (bus_wdata != RESTART_KEY);
    bus_rdata  = (bus_addr == 1'b0) ? mode_q : '0;
  end

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  wdt_mode_reg u_mode (
    .clk(clk), .rst_n(rst_i_n), .wr_mode(wr_mode), .wdata(bus_wdata),
    .mode_q(mode_q), .accept(mode_accept)
  );

  wdt_src_sel #(
    .LOW_EXP_BASE(LOW_EXP_BASE), .SYS_EXP_BASE(SYS_EXP_BASE), .SH_W(SH_W)
  ) u_sel (
    .clk(clk), .rst_n(rst_i_n), .sel_bits(mode_q[4:3]), .exp_bits(mode_q[2:0]),
    .ls_locked(ls_locked), .ls_strobe(ls_strobe), .sys_strobe(sys_strobe),
    .tick(tick), .shamt(shamt)
  );

  wdt_counter #(.CNT_W(CNT_W), .SH_W(SH_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .shamt(shamt),
    .clear(key_ok || mode_accept), .fault(key_bad), .req(wdt_reset_req)
  );

  // R1: the reset request stays low in the first cycle after reset release
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> !wdt_reset_req);
  // R9: a bad restart value always yields a request next cycle
  assert_bad_key_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    key_bad |=> wdt_reset_req);
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ls_strobe, sys_strobe, ls_locked;
  logic       bus_addr, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       wdt_reset_req;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wdog_timer #(.LOW_EXP_BASE(1), .SYS_EXP_BASE(2)) dut (
    .clk(clk), .rst_n(rst_n), .ls_strobe(ls_strobe), .sys_strobe(sys_strobe),
    .ls_locked(ls_locked), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_reset_req(wdt_reset_req)
  );

  typedef struct packed {
    logic        lock;
    logic [7:0]  mode;
    logic        use_sys;
    logic [15:0] period;
  } vec_t;

  // period = 2^(1+n) low-speed or 2^(2+n) system strobes with the bench bases
  localparam vec_t VECS [7] = '{
    '{1'b0, 8'h60, 1'b0, 16'd2},
    '{1'b0, 8'h62, 1'b0, 16'd8},
    '{1'b0, 8'h64, 1'b0, 16'd32},
    '{1'b0, 8'h69, 1'b1, 16'd8},
    '{1'b0, 8'h6F, 1'b1, 16'd512},
    '{1'b1, 8'h6B, 1'b0, 16'd16},
    '{1'b1, 8'h73, 1'b0, 16'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic do_reset(input logic lock);
    @(negedge clk);
    rst_n = 1'b0; ls_strobe = 0; sys_strobe = 0; ls_locked = lock;
    bus_addr = 0; bus_wr = 0; bus_wdata = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic ls, input logic sy);
    ls_strobe = ls; sys_strobe = sy;
    @(negedge clk);
    ls_strobe = 0; sys_strobe = 0;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic read_mode(input logic [7:0] exp, input string req);
    bus_addr = 1'b0;
    #1;
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  // counts right-source strobes until the request; -1 if wrong source fires it
  task automatic measure(input logic use_sys, output int ticks);
    ticks = 0;
    for (int i = 0; i < 1100; i++) begin
      step(use_sys, !use_sys);
      if (wdt_reset_req) begin ticks = -1; return; end
      step(!use_sys, use_sys);
      if (wdt_reset_req) begin ticks = i + 1; return; end
    end
  endtask

  task automatic n_ticks_quiet(input logic use_sys, input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      step(!use_sys, use_sys);
      if (wdt_reset_req) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  initial begin
    int t;
    rst_n = 1'b0; ls_strobe = 0; sys_strobe = 0; ls_locked = 0;
    bus_addr = 0; bus_wr = 0; bus_wdata = 0;

    // R1 reset state and default period 2^(1+7)
    do_reset(1'b0);
    check(wdt_reset_req == 1'b0, "R1 req low", wdt_reset_req, 0);
    read_mode(8'h67, "R1 reset value");
    measure(1'b0, t);
    check(t == 256, "R1 default period", t, 256);

    // vector table: R5 source, R6 period and pulse width, R7 strap
    foreach (VECS[k]) begin
      do_reset(VECS[k].lock);
      bus_write(1'b0, VECS[k].mode);
      read_mode(VECS[k].mode, "R2 readback");
      measure(VECS[k].use_sys, t);
      check(t == int'(VECS[k].period), VECS[k].lock ? "R7 locked period" : "R6 period",
            t, VECS[k].period);
      step(1'b0, 1'b0);
      check(wdt_reset_req == 1'b0, "R6 one-cycle pulse", wdt_reset_req, 0);
      measure(VECS[k].use_sys, t);
      check(t == int'(VECS[k].period), "R6 restart after overflow", t, VECS[k].period);
    end

    // R3 second write ignored
    do_reset(1'b0);
    bus_write(1'b0, 8'h60);
    bus_write(1'b0, 8'h6F);
    read_mode(8'h60, "R3 second write");
    measure(1'b0, t);
    check(t == 2, "R3 period kept", t, 2);

    // R4 illegal tag ignored and single write not used up
    do_reset(1'b0);
    bus_write(1'b0, 8'h40);
    read_mode(8'h67, "R4 illegal ignored");
    bus_write(1'b0, 8'hE1);
    read_mode(8'h67, "R4 illegal ignored 2");
    bus_write(1'b0, 8'h61);
    read_mode(8'h61, "R4 later legal write");

    // R5 stop code: no request with both strobes running
    do_reset(1'b0);
    bus_write(1'b0, 8'h70);
    begin
      bit seen = 0;
      for (int i = 0; i < 700; i++) begin
        step(1'b1, 1'b1);
        if (wdt_reset_req) seen = 1;
      end
      check(!seen, "R5 stopped", seen, 0);
    end

    // R2 accepted write clears the counter
    do_reset(1'b0);
    n_ticks_quiet(1'b0, 3, "R2 pre-write quiet");
    bus_write(1'b0, 8'h60);
    measure(1'b0, t);
    check(t == 2, "R2 write clears count", t, 2);

    // R8 restart key clears the count
    do_reset(1'b0);
    bus_write(1'b0, 8'h62);
    n_ticks_quiet(1'b0, 5, "R8 pre-key quiet");
    bus_write(1'b1, 8'hAC);
    check(wdt_reset_req == 1'b0, "R8 key no request", wdt_reset_req, 0);
    measure(1'b0, t);
    check(t == 8, "R8 full period after key", t, 8);

    // R9 wrong restart value
    do_reset(1'b0);
    bus_write(1'b0, 8'h62);
    n_ticks_quiet(1'b0, 5, "R9 pre-fault quiet");
    bus_write(1'b1, 8'h55);
    check(wdt_reset_req == 1'b1, "R9 fault request", wdt_reset_req, 1);
    step(1'b0, 1'b0);
    check(wdt_reset_req == 1'b0, "R9 fault pulse width", wdt_reset_req, 0);
    measure(1'b0, t);
    check(t == 8, "R9 count cleared", t, 8);
    bus_addr = 1'b1;
    #1;
    check(bus_rdata == 8'h00, "R9 restart reads zero", bus_rdata, 0);

    finish_run();
  end
endmodule